// File: doc/BRIEF.md
# Single-Precision Compare, Sign-Injection and Min/Max Unit

This block executes the non-arithmetic single-precision floating-point operations of a scalar pipeline. These are the three ordered and equality compares, minimum and maximum, the three sign-injection forms, and operand classification. The caller presents two 32-bit operands with a function code and pulses `in_valid` for one cycle. Some cycles later the unit pulses `out_valid` with a 32-bit result and an invalid-operation flag. The result is either a float, a 0/1 integer, or a class mask.

Each operation has a fixed latency and its own rule for subnormal operands. The compares first replace each subnormal with a zero of the same sign. Minimum, maximum and sign injection work on the exact bit patterns. Classification reports subnormals as a class of their own. Only one operation is in flight at a time. A strobe that arrives while a two-cycle operation is still in its middle stage is dropped.

Top module: `fp_cmpsel_unit`

## Requirements
- R1: Function codes 0 (less-than), 1 (less-or-equal) and 2 (equal) assert `out_valid` one cycle after acceptance. `out_data` is 1 when the relation holds and 0 when it does not, and bits 31:1 are zero. A zero of either sign equals a zero of either sign.
- R2: Before it compares, each compare treats an operand with exponent 0 and a non-zero fraction as a zero of the same sign.
- R3: A compare with any NaN operand returns 0. Less-than and less-or-equal raise `out_nv` for any NaN. Equal raises `out_nv` only when an operand is signaling, that is when fraction bit 22 is 0. `out_nv` is 0 in every cycle where `out_valid` is 0.
- R4: Code 3 (minimum) returns a when a < b and returns b otherwise. Code 4 (maximum) returns b when a < b and returns a otherwise. Both assert `out_valid` two cycles after acceptance.
- R5: For minimum and maximum, if exactly one operand is a NaN the other operand is returned. If both are NaN the result is 0x7FC00000. `out_nv` is raised when any operand is a signaling NaN.
- R6: Minimum and maximum order subnormals by their true values without flushing, and they place -0 below +0.
- R7: Codes 5, 6 and 7 complete in one cycle. Result bits 30:0 equal a[30:0]. Bit 31 is b[31] for code 5, the inverse of b[31] for code 6, and a[31] XOR b[31] for code 7. `out_nv` is 0.
- R8: Code 8 completes in two cycles and returns a one-hot mask in bits 9:0, with bits 31:10 zero. From bit 0 upward the bits mean: -inf, negative normal, negative subnormal, -0, +0, positive subnormal, positive normal, +inf, signaling NaN, quiet NaN.
- R9: The unit ignores an `in_valid` pulse in the cycle after a two-cycle operation was accepted. That pulse produces no `out_valid`.
- R10: After reset `out_valid` and `out_nv` are 0.
- R11: Function codes 9 to 15 are ignored and produce no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | One-cycle request strobe |
| in_func | input | 4 | Function code (0 to 8) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | One-cycle completion strobe |
| out_data | output | 32 | Result, held until the next completion |
| out_nv | output | 1 | Invalid-operation flag, valid with `out_valid` |

## Verification
The hardest cases to reach are the places where the subnormal rules split. The same pair, such as a positive subnormal against +0 or -0 against +0, must compare equal under the compares yet stay ordered under minimum and maximum. Signaling and quiet NaNs of both signs raise different flags in equal than in less-than. To reach all of these, the bench sweeps every ordered pair from a 20-value set of edge operands across all nine functions. The set includes both zeros, the smallest and largest subnormals of each sign, normals, infinities and NaNs of both kinds. Separate sequences drive a strobe into the middle stage of a two-cycle operation and drive undefined function codes.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int WORD_W  = 1 + EXP_W + MAN_W;
  localparam int CLASS_W = 10;

  typedef enum logic [3:0] {
    FN_LT    = 4'd0,
    FN_LE    = 4'd1,
    FN_EQ    = 4'd2,
    FN_MIN   = 4'd3,
    FN_MAX   = 4'd4,
    FN_SGNJ  = 4'd5,
    FN_SGNJN = 4'd6,
    FN_SGNJX = 4'd7,
    FN_CLASS = 4'd8
  } fn_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic sub;
    logic norm;
    logic inf;
    logic snan;
    logic qnan;
  } opnd_info_t;

  localparam logic [WORD_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
endpackage

// File: rtl/fcs_rst_sync.sv
module fcs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/fcs_opnd_decode.sv
module fcs_opnd_decode
  import fcs_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output opnd_info_t        info_o
);
  logic exp_ones, exp_zero, man_nz;

  always_comb begin
    exp_ones = &word_i[WORD_W-2:MAN_W];
    exp_zero = ~|word_i[WORD_W-2:MAN_W];
    man_nz   = |word_i[MAN_W-1:0];
    info_o.sign = word_i[WORD_W-1];
    info_o.zero = exp_zero & ~man_nz;
    info_o.sub  = exp_zero & man_nz;
    info_o.norm = ~exp_zero & ~exp_ones;
    info_o.inf  = exp_ones & ~man_nz;
    info_o.snan = exp_ones & man_nz & ~word_i[MAN_W-1];
    info_o.qnan = exp_ones & word_i[MAN_W-1];
  end
endmodule

// File: rtl/fcs_order.sv
module fcs_order
  import fcs_pkg::*;
#(
  parameter bit FLUSH_SUB   = 1'b1,
  parameter bit SIGNED_ZERO = 1'b0
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              lt_o,
  output logic              eq_o
);
  localparam int MAG_W = WORD_W - 1;

  logic [MAG_W-1:0] mag_a, mag_b;
  logic             sa, sb, both_zero;

  always_comb begin
    sa    = a_i[WORD_W-1];
    sb    = b_i[WORD_W-1];
    mag_a = a_i[MAG_W-1:0];
    mag_b = b_i[MAG_W-1:0];
    if (FLUSH_SUB) begin
      if (~|a_i[WORD_W-2:MAN_W]) mag_a = '0;
      if (~|b_i[WORD_W-2:MAN_W]) mag_b = '0;
    end
    both_zero = ~|mag_a & ~|mag_b;
    if (both_zero) begin
      lt_o = SIGNED_ZERO & sa & ~sb;
      eq_o = ~SIGNED_ZERO | (sa == sb);
    end else if (sa != sb) begin
      lt_o = sa;
      eq_o = 1'b0;
    end else begin
      lt_o = sa ? (mag_a > mag_b) : (mag_a < mag_b);
      eq_o = (mag_a == mag_b);
    end
  end
endmodule

// File: rtl/fcs_classify.sv
module fcs_classify
  import fcs_pkg::*;
(
  input  opnd_info_t         info_i,
  output logic [CLASS_W-1:0] mask_o
);
  always_comb begin
    mask_o    = '0;
    mask_o[0] = info_i.sign & info_i.inf;
    mask_o[1] = info_i.sign & info_i.norm;
    mask_o[2] = info_i.sign & info_i.sub;
    mask_o[3] = info_i.sign & info_i.zero;
    mask_o[4] = ~info_i.sign & info_i.zero;
    mask_o[5] = ~info_i.sign & info_i.sub;
    mask_o[6] = ~info_i.sign & info_i.norm;
    mask_o[7] = ~info_i.sign & info_i.inf;
    mask_o[8] = info_i.snan;
    mask_o[9] = info_i.qnan;
  end
endmodule

// File: rtl/fp_cmpsel_unit.sv
module fp_cmpsel_unit
  import fcs_pkg::*;
#(
  parameter int FUNC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FUNC_W-1:0] in_func,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_nv
);
  localparam logic [FUNC_W-1:0] LAST_FN = FUNC_W'(FN_CLASS);

  logic rst_sync_n;
  fcs_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n));

  // operand decode, one instance per operand
  logic [WORD_W-1:0] opnd [2];
  opnd_info_t        info [2];
  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    fcs_opnd_decode u_dec (.word_i(opnd[g]), .info_o(info[g]));
  end

  logic cmp_lt, cmp_eq, mm_lt, mm_eq;
  fcs_order #(.FLUSH_SUB(1'b1), .SIGNED_ZERO(1'b0)) u_cmp_order (
    .a_i(in_a), .b_i(in_b), .lt_o(cmp_lt), .eq_o(cmp_eq));
  fcs_order #(.FLUSH_SUB(1'b0), .SIGNED_ZERO(1'b1)) u_mm_order (
    .a_i(in_a), .b_i(in_b), .lt_o(mm_lt), .eq_o(mm_eq));

  logic [CLASS_W-1:0] class_mask;
  fcs_classify u_class (.info_i(info[0]), .mask_o(class_mask));

  // combinational result selection
  logic              a_nan, b_nan, any_nan, any_snan;
  logic              fn_legal, fn_two_cyc, accept;
  logic [WORD_W-1:0] res_c;
  logic              nv_c;
  logic              unused_eq;

  assign unused_eq = mm_eq;

  always_comb begin
    a_nan    = info[0].snan | info[0].qnan;
    b_nan    = info[1].snan | info[1].qnan;
    any_nan  = a_nan | b_nan;
    any_snan = info[0].snan | info[1].snan;
    fn_legal = (in_func <= LAST_FN);
    fn_two_cyc = (in_func == FUNC_W'(FN_MIN)) || (in_func == FUNC_W'(FN_MAX)) ||
                 (in_func == FUNC_W'(FN_CLASS));
    res_c = '0;
    nv_c  = 1'b0;
    case (in_func)
      FUNC_W'(FN_LT): begin
        res_c[0] = ~any_nan & cmp_lt;
        nv_c     = any_nan;
      end
      FUNC_W'(FN_LE): begin
        res_c[0] = ~any_nan & (cmp_lt | cmp_eq);
        nv_c     = any_nan;
      end
      FUNC_W'(FN_EQ): begin
        res_c[0] = ~any_nan & cmp_eq;
        nv_c     = any_snan;
      end
      FUNC_W'(FN_MIN), FUNC_W'(FN_MAX): begin
        nv_c = any_snan;
        if (a_nan && b_nan)      res_c = CANON_NAN;
        else if (a_nan)          res_c = in_b;
        else if (b_nan)          res_c = in_a;
        else if (in_func == FUNC_W'(FN_MIN)) res_c = mm_lt ? in_a : in_b;
        else                     res_c = mm_lt ? in_b : in_a;
      end
      FUNC_W'(FN_SGNJ):  res_c = {in_b[WORD_W-1], in_a[WORD_W-2:0]};
      FUNC_W'(FN_SGNJN): res_c = {~in_b[WORD_W-1], in_a[WORD_W-2:0]};
      FUNC_W'(FN_SGNJX): res_c = {in_a[WORD_W-1] ^ in_b[WORD_W-1], in_a[WORD_W-2:0]};
      FUNC_W'(FN_CLASS): res_c = {{(WORD_W-CLASS_W){1'b0}}, class_mask};
      default: begin
        res_c = '0;
        nv_c  = 1'b0;
      end
    endcase
  end

  // pipeline state
  logic              mid_valid_q, mid_valid_d;
  logic [WORD_W-1:0] mid_data_q, mid_data_d;
  logic              mid_nv_q, mid_nv_d;
  logic              mid_en;
  logic              out_valid_q, out_valid_d;
  logic [WORD_W-1:0] out_data_q, out_data_d;
  logic              out_nv_q, out_nv_d;
  logic              out_en;

  always_comb begin
    accept      = in_valid & ~mid_valid_q & fn_legal;
    mid_en      = accept & fn_two_cyc;
    mid_valid_d = mid_en;
    mid_data_d  = res_c;
    mid_nv_d    = nv_c;
    out_valid_d = (accept & ~fn_two_cyc) | mid_valid_q;
    out_en      = out_valid_d;
    out_data_d  = mid_valid_q ? mid_data_q : res_c;
    out_nv_d    = out_valid_d & (mid_valid_q ? mid_nv_q : nv_c);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mid_valid_q <= 1'b0;
      mid_data_q  <= '0;
      mid_nv_q    <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_nv_q    <= 1'b0;
    end else begin
      mid_valid_q <= mid_valid_d;
      if (mid_en) begin
        mid_data_q <= mid_data_d;
        mid_nv_q   <= mid_nv_d;
      end
      out_valid_q <= out_valid_d;
      out_nv_q    <= out_nv_d;
      if (out_en) out_data_q <= out_data_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_nv    = out_nv_q;
endmodule

// File: rtl/fp_cmpsel_unit_chk.sv
module fp_cmpsel_unit_chk
  import fcs_pkg::*;
#(
  parameter int FUNC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [FUNC_W-1:0] in_func,
  input logic [WORD_W-1:0] in_a,
  input logic              mid_valid_q,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data,
  input logic              out_nv
);
  logic acc_cmp, acc_sgn, acc_two, acc_cls;

  always_comb begin
    acc_cmp = in_valid && !mid_valid_q && (in_func <= FUNC_W'(FN_EQ));
    acc_sgn = in_valid && !mid_valid_q && (in_func >= FUNC_W'(FN_SGNJ)) &&
              (in_func <= FUNC_W'(FN_SGNJX));
    acc_two = in_valid && !mid_valid_q &&
              ((in_func == FUNC_W'(FN_MIN)) || (in_func == FUNC_W'(FN_MAX)) ||
               (in_func == FUNC_W'(FN_CLASS)));
    acc_cls = in_valid && !mid_valid_q && (in_func == FUNC_W'(FN_CLASS));
  end

  // R1: compare done next cycle with a 0/1 result
  p_cmp_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cmp |=> (out_valid && out_data[WORD_W-1:1] == '0));

  // R3: flag only alongside a completion
  p_nv_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_nv);

  // R4: two-cycle operations complete after exactly two edges
  p_two_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_two |=> (!out_valid ##1 out_valid));

  // R7: sign injection keeps magnitude bits, one-cycle
  p_sgn_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sgn |=> (out_valid && out_data[WORD_W-2:0] == $past(in_a[WORD_W-2:0]) && !out_nv));

  // R8: class result is one-hot in the low field
  p_class_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cls |=> ##1 ($countones(out_data[CLASS_W-1:0]) == 1 &&
                     out_data[WORD_W-1:CLASS_W] == '0));

  // R9: no new two-cycle operation starts while one is in the middle stage
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mid_valid_q |=> !mid_valid_q);
endmodule

bind fp_cmpsel_unit fp_cmpsel_unit_chk #(.FUNC_W(FUNC_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_func(in_func),
  .in_a(in_a), .mid_valid_q(mid_valid_q), .out_valid(out_valid),
  .out_data(out_data), .out_nv(out_nv));

// File: tb/fp_cmpsel_unit_tb_top.sv
`timescale 1ns/1ps
module fp_cmpsel_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_func = 4'd0;
  logic [31:0] in_a = 32'd0;
  logic [31:0] in_b = 32'd0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_nv;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fp_cmpsel_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_func(in_func),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data),
    .out_nv(out_nv));

  function automatic logic [31:0] pick(input int i);
    case (i)
      0:  return 32'h0000_0000;  1:  return 32'h8000_0000;
      2:  return 32'h0000_0001;  3:  return 32'h8000_0001;
      4:  return 32'h007F_FFFF;  5:  return 32'h807F_FFFF;
      6:  return 32'h0080_0000;  7:  return 32'h8080_0000;
      8:  return 32'h3F80_0000;  9:  return 32'hBF80_0000;
      10: return 32'h3FC0_0000;  11: return 32'h7F7F_FFFF;
      12: return 32'hFF7F_FFFF;  13: return 32'h7F80_0000;
      14: return 32'hFF80_0000;  15: return 32'h7FC0_0000;
      16: return 32'hFFC0_0001;  17: return 32'h7F80_0001;
      18: return 32'hFFA0_0000;  default: return 32'h0040_0000;
    endcase
  endfunction

  function automatic bit is_nan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [31:0] w);
    return is_nan(w) && !w[22];
  endfunction
  function automatic bit is_sub(input logic [31:0] w);
    return (w[30:23] == 8'h00) && (w[22:0] != 0);
  endfunction
  function automatic longint key(input logic [31:0] w, input bit flush);
    longint m;
    m = longint'(w[30:0]);
    if (flush && w[30:23] == 8'h00) m = 0;
    return w[31] ? -m : m;
  endfunction

  task automatic model(input logic [3:0] f, input logic [31:0] a, b,
                       output logic [31:0] d, output logic nv,
                       output int lat, output string tag);
    bit anan, snan, lt, eq;
    int idx;
    anan = is_nan(a) || is_nan(b);
    snan = is_snan(a) || is_snan(b);
    d = 32'd0; nv = 1'b0; lat = 1; tag = "R1";
    if (f <= 4'd2) begin
      lt = key(a, 1) < key(b, 1);
      eq = key(a, 1) == key(b, 1);
      tag = anan ? "R3" : ((is_sub(a) || is_sub(b)) ? "R2" : "R1");
      if (!anan) d[0] = (f == 4'd0) ? lt : (f == 4'd1) ? (lt || eq) : eq;
      nv = (f == 4'd2) ? snan : anan;
    end else if (f <= 4'd4) begin
      lat = 2;
      nv = snan;
      lt = (key(a, 0) < key(b, 0)) || (key(a, 0) == key(b, 0) && a[31] && !b[31]);
      tag = anan ? "R5" : ((is_sub(a) || is_sub(b) || a[30:0] == 0 || b[30:0] == 0) ? "R6" : "R4");
      if (is_nan(a) && is_nan(b)) d = 32'h7FC0_0000;
      else if (is_nan(a)) d = b;
      else if (is_nan(b)) d = a;
      else if (f == 4'd3) d = lt ? a : b;
      else d = lt ? b : a;
    end else if (f <= 4'd7) begin
      tag = "R7";
      d[30:0] = a[30:0];
      d[31] = (f == 4'd5) ? b[31] : (f == 4'd6) ? ~b[31] : (a[31] ^ b[31]);
    end else begin
      tag = "R8";
      lat = 2;
      if (a[30:23] == 8'hFF) idx = (a[22:0] == 0) ? (a[31] ? 0 : 7) : (a[22] ? 9 : 8);
      else if (a[30:23] == 8'h00) idx = (a[22:0] == 0) ? (a[31] ? 3 : 4) : (a[31] ? 2 : 5);
      else idx = a[31] ? 1 : 6;
      d = 32'd1 << idx;
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] f, input logic [31:0] a, b,
                        output logic [31:0] d, output logic nv, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_func = f; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    d = out_data; nv = out_nv;
  endtask

  task automatic watch_quiet(input string tag, input int n);
    int seen;
    seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk(tag, "unexpected completions", 32'(seen), 32'd0);
  endtask

  initial begin : watchdog
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [31:0] d, ed;
    logic nv, env;
    int lat, elat;
    string tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R10", "out_nv after reset", {31'd0, out_nv}, 32'd0);

    for (int f = 0; f <= 8; f++) begin
      for (int i = 0; i < 20; i++) begin
        for (int j = 0; j < 20; j++) begin
          model(4'(f), pick(i), pick(j), ed, env, elat, tag);
          run_op(4'(f), pick(i), pick(j), d, nv, lat);
          chk(tag, $sformatf("data f=%0d a=%h b=%h", f, pick(i), pick(j)), d, ed);
          chk(tag, $sformatf("nv f=%0d a=%h b=%h", f, pick(i), pick(j)), {31'd0, nv}, {31'd0, env});
          chk(tag, $sformatf("latency f=%0d", f), 32'(lat), 32'(elat));
        end
      end
    end

    // R9: strobe into the middle stage of a minimum is dropped
    @(negedge clk);
    in_valid = 1'b1; in_func = 4'd3; in_a = 32'h3F80_0000; in_b = 32'hBF80_0000;
    @(negedge clk);
    in_func = 4'd0; in_a = 32'h0000_0000; in_b = 32'h3F80_0000;
    chk("R9", "no early completion", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "min completes", {31'd0, out_valid}, 32'd1);
    chk("R9", "min result kept", out_data, 32'hBF80_0000);
    watch_quiet("R9", 4);

    // R11: undefined codes are ignored
    for (int f = 9; f < 16; f++) begin
      @(negedge clk);
      in_valid = 1'b1; in_func = 4'(f); in_a = 32'h3F80_0000; in_b = 32'h3F80_0000;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R11", "undefined code output", {31'd0, out_valid}, 32'd0);
      watch_quiet("R11", 3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule